// File: doc/BRIEF.md
# Register-Mapped A/D Conversion Sequencer

This block is the digital control side of a 12-bit analog acquisition channel that sits behind a byte-wide register bus with sixteen byte locations. Software programs a gain code, an input selector and an operating mode through write-only registers. Writes to two further locations act as commands: one starts a conversion and the other clears a pending interrupt. The data value of these command writes does not matter.

A conversion starts from one of two sources. The first is a software command write. The second is an external pacer pulse from a timer outside this block. Which source is active depends on the mode code. Once a conversion is accepted, the block pulses a start strobe to the converter and raises a busy flag. It then waits a fixed, parameterised number of cycles, which stands in for the converter latency. After that wait it captures the converter's 12-bit result port and drops busy. Software reads the result as two bytes, and the busy flag shares a byte with the upper result bits. In the interrupt mode, each completed conversion sets a status bit. That bit drives one of several interrupt request lines, and the line is chosen by a separate field in the mode register.

A static input pin picks single-ended or differential input wiring. The selector presented to the analog multiplexer is adjusted to match this pin.

Top module: `adc_acq_ctrl`

## Requirements
- R1: Reading offset 4 returns result bits 7:0. Reading offset 5 returns result bits 11:8 in bits 3:0, the busy flag in bit 4, and zero in bits 7:5. Every other offset reads zero.
- R2: Busy reads 1 for exactly CONV_CYCLES cycles after a conversion is accepted. On the edge where busy falls, the result register captures `cvt_result`, and the result is otherwise unchanged.
- R3: A write of any data value to offset 0xC starts a conversion when mode bits 2:0 of offset 0xB equal 001 (software trigger, polled). `cvt_start` is high for the single cycle after the accepting edge.
- R4: A high `pacer_tick` starts a conversion when the mode code is 010 (pacer trigger, polled) or 110 (pacer trigger, interrupt). Software triggers are ignored in these two modes. The pacer is ignored in mode 001. Every other code, including the reset value 000, disables both sources.
- R5: A trigger that arrives while busy is 1 is ignored. The conversion in flight is neither restarted nor lengthened, and no start pulse is issued.
- R6: In mode 110, each completed conversion sets an interrupt status bit. A write of any value to offset 8 clears it, and a clear in the same cycle as a completion takes priority. In the other modes, completions leave the status unchanged.
- R7: Mode register bits 6:4 choose the request line, and `irq_req[n]` is high when the status is set and line n is selected. Codes 000 and 010 select line 2. Code 001 selects no line. Codes 011 to 111 select lines 3 to 7. At most one line is high.
- R8: Offset 0xA holds a 4-bit selector. With `diff_mode` = 0, `mux_sel` equals the selector. With `diff_mode` = 1, `mux_sel` is {0, selector bits 2:0}, so selector bit 3 is ignored.
- R9: Offset 9 stores data bits 1:0 as the gain code on `gain_code`, and upper data bits have no effect.
- R10: After reset the mode is 000, busy is 0, the interrupt status is clear, the result reads zero, and `gain_code`, `mux_sel` and `irq_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| diff_mode | input | 1 | Static wiring select: 1 = differential pairs |
| pacer_tick | input | 1 | External pacer trigger pulse |
| cvt_start | output | 1 | One-cycle start strobe to the converter |
| cvt_result | input | 12 | Converter result, sampled at completion |
| mux_sel | output | 4 | Input selector to the analog multiplexer |
| gain_code | output | 2 | Gain code to the amplifier |
| irq_req | output | 8 | Interrupt request lines, one per line number |

## Verification
The assertions assume that `pacer_tick` and command writes are sampled on single clock edges. They also assume that `diff_mode` behaves as a level that the selector logic follows combinationally, with no timing of its own. The stimulus drives every input half a cycle away from the active edge, and it changes `diff_mode` only while no check depends on the previous wiring. The stimulus deliberately places triggers inside busy windows and in the wrong modes, places clears while the status is set, and walks all eight line codes. A long stretch of random writes and pacer pulses then mixes these cases, while the bench model tracks expected read data, start strobes, selector, gain and request lines on every clock.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    localparam int BUS_AW = 4;
    localparam int BUS_DW = 8;

    // Register byte offsets
    localparam logic [BUS_AW-1:0] OFS_RES_LO  = 4'h4;
    localparam logic [BUS_AW-1:0] OFS_RES_HI  = 4'h5;
    localparam logic [BUS_AW-1:0] OFS_IRQ_CLR = 4'h8;
    localparam logic [BUS_AW-1:0] OFS_GAIN    = 4'h9;
    localparam logic [BUS_AW-1:0] OFS_SEL     = 4'hA;
    localparam logic [BUS_AW-1:0] OFS_MODE    = 4'hB;
    localparam logic [BUS_AW-1:0] OFS_SW_TRIG = 4'hC;

    typedef enum logic [2:0] {
        MODE_OFF        = 3'b000,
        MODE_SW_POLL    = 3'b001,
        MODE_PACER_POLL = 3'b010,
        MODE_PACER_INT  = 3'b110
    } acq_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] line_code;
        logic [3:0] sel;
        logic [1:0] gain;
    } acq_cfg_t;

    typedef struct packed {
        logic sw_trig;
        logic irq_clr;
    } acq_cmd_t;

    function automatic logic sw_enabled(input logic [2:0] mode);
        return mode == MODE_SW_POLL;
    endfunction

    function automatic logic pacer_enabled(input logic [2:0] mode);
        return (mode == MODE_PACER_POLL) || (mode == MODE_PACER_INT);
    endfunction

    // Request-line decode: 000 and 010 alias to line 2, 001 selects nothing
    function automatic logic line_valid(input logic [2:0] code);
        return code != 3'b001;
    endfunction

    function automatic logic [2:0] line_number(input logic [2:0] code);
        return (code == 3'b000) ? 3'd2 : code;
    endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr,
    input  logic [BUS_DW-1:0] wdata,
    output acq_cfg_t          cfg,
    output acq_cmd_t          cmd
);

    acq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            case (addr)
                OFS_GAIN: cfg_q.gain <= wdata[1:0];
                OFS_SEL:  cfg_q.sel  <= wdata[3:0];
                OFS_MODE: begin
                    cfg_q.mode      <= wdata[2:0];
                    cfg_q.line_code <= wdata[6:4];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd.sw_trig = wr && (addr == OFS_SW_TRIG);
        cmd.irq_clr = wr && (addr == OFS_IRQ_CLR);
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_acq_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic             sw_trig,
    input  logic             pacer,
    input  logic [RES_W-1:0] cvt_result,
    output logic             busy,
    output logic             start,
    output logic             finish,
    output logic [RES_W-1:0] result
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    logic             busy_q;
    logic             start_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] res_q;
    logic             accept;

    always_comb begin
        accept = !busy_q && ((sw_trig && sw_enabled(mode)) ||
                             (pacer && pacer_enabled(mode)));
        finish = busy_q && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            cnt_q   <= '0;
            res_q   <= '0;
        end else begin
            start_q <= accept;
            if (accept) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_LOAD;
            end else if (finish) begin
                busy_q <= 1'b0;
                res_q  <= cvt_result;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy   = busy_q;
    assign start  = start_q;
    assign result = res_q;

    AST_BUSY_COUNTS: assert property (@(posedge clk) disable iff (rst)
        busy_q && (cnt_q != '0) |=> busy_q && (cnt_q == $past(cnt_q) - 1'b1)); // R5
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        busy_q && (cnt_q == '0) |=> !busy_q); // R2
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_q |-> busy_q && !$past(busy_q)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(res_q)); // R2

endmodule

// File: rtl/adc_irq_ctl.sv
module adc_irq_ctl
    import adc_acq_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           mode,
    input  logic [2:0]           line_code,
    input  logic                 finish,
    input  logic                 clr,
    output logic [NUM_LINES-1:0] irq
);

    localparam int LINE_W = $clog2(NUM_LINES);

    logic       pend_q;
    logic       hit_ok;
    logic [2:0] hit_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (clr) begin
            pend_q <= 1'b0;
        end else if (finish && (mode == MODE_PACER_INT)) begin
            pend_q <= 1'b1;
        end
    end

    always_comb begin
        hit_ok   = line_valid(line_code);
        hit_line = line_number(line_code);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign irq[i] = pend_q && hit_ok && (LINE_W'(hit_line) == LINE_W'(i));
    end

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq)); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend_q); // R6
    AST_SET_ONLY_INT: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(mode) == MODE_PACER_INT && $past(finish)); // R6

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
    import adc_acq_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 400,
    parameter int NUM_LINES   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 diff_mode,
    input  logic                 pacer_tick,
    output logic                 cvt_start,
    input  logic [RES_W-1:0]     cvt_result,
    output logic [3:0]           mux_sel,
    output logic [1:0]           gain_code,
    output logic [NUM_LINES-1:0] irq_req
);

    localparam int HI_W = RES_W - BUS_DW;

    acq_cfg_t         cfg;
    acq_cmd_t         cmd;
    logic             busy;
    logic             finish;
    logic [RES_W-1:0] result;
    logic [7:0]       hi_byte;

    adc_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .cfg   (cfg),
        .cmd   (cmd)
    );

    adc_conv_seq #(
        .RES_W       (RES_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (cfg.mode),
        .sw_trig    (cmd.sw_trig),
        .pacer      (pacer_tick),
        .cvt_result (cvt_result),
        .busy       (busy),
        .start      (cvt_start),
        .finish     (finish),
        .result     (result)
    );

    adc_irq_ctl #(
        .NUM_LINES (NUM_LINES)
    ) u_irq (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg.mode),
        .line_code (cfg.line_code),
        .finish    (finish),
        .clr       (cmd.irq_clr),
        .irq       (irq_req)
    );

    always_comb begin
        hi_byte             = '0;
        hi_byte[HI_W-1:0]   = result[RES_W-1:BUS_DW];
        hi_byte[HI_W]       = busy;
        case (bus_addr)
            OFS_RES_LO: bus_rdata = result[BUS_DW-1:0];
            OFS_RES_HI: bus_rdata = hi_byte;
            default:    bus_rdata = '0;
        endcase
    end

    assign mux_sel   = diff_mode ? {1'b0, cfg.sel[2:0]} : cfg.sel;
    assign gain_code = cfg.gain;

    AST_DIFF_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        diff_mode |-> !mux_sel[3]); // R8
    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_RES_HI) |-> (bus_rdata[7:5] == 3'b000)); // R1

endmodule

// File: tb/sim_adc_acq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_acq_ctrl;

    localparam int CONV = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        diff_mode;
    logic        pacer_tick;
    logic        cvt_start;
    logic [11:0] cvt_result;
    logic [3:0]  mux_sel;
    logic [1:0]  gain_code;
    logic [7:0]  irq_req;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_acq_ctrl #(.CONV_CYCLES(CONV)) u0 (.*);

    // Behavioural reference state
    int   m_mode, m_line, m_sel, m_gain, m_left, m_res;
    bit   m_flag, m_start;

    function automatic int exp_rdata(int a);
        if (a == 4) return m_res & 8'hFF;
        if (a == 5) return ((m_left > 0) ? 16 : 0) + (m_res >> 8);
        return 0;
    endfunction

    function automatic int exp_irq();
        int ln;
        if (!m_flag || m_line == 1) return 0;
        ln = (m_line == 0) ? 2 : m_line;
        return 1 << ln;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_line = 0; m_sel = 0; m_gain = 0;
        m_left = 0; m_res = 0; m_flag = 0; m_start = 0;
    endtask

    task automatic model_edge(int a, bit w, int d, bit p, int cv);
        bit fin, acc, trig;
        fin  = (m_left == 1);
        trig = (w && a == 12 && m_mode == 1) ||
               (p && (m_mode == 2 || m_mode == 6));
        acc  = (m_left == 0) && trig;
        if (w && a == 8) m_flag = 0;
        else if (fin && m_mode == 6) m_flag = 1;
        if (fin) m_res = cv;
        if (acc) m_left = CONV;
        else if (m_left > 0) m_left--;
        m_start = acc;
        if (w) begin
            if (a == 9)  m_gain = d % 4;
            if (a == 10) m_sel  = d % 16;
            if (a == 11) begin m_mode = d % 8; m_line = (d / 16) % 8; end
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model
    task automatic cyc(int a, bit w = 0, int d = 0, bit p = 0);
        int cv;
        cv = $urandom % 4096;
        bus_addr = 4'(a); bus_wr = w; bus_wdata = 8'(d);
        pacer_tick = p; cvt_result = 12'(cv);
        #1;
        chk((a == 4 || a == 5) ? "R1 R2 read" : "R1 R10 read", int'(bus_rdata), exp_rdata(a));
        chk("R3 R4 R5 start", int'(cvt_start), int'(m_start));
        chk("R6 R7 irq", int'(irq_req), exp_irq());
        chk("R8 selector", int'(mux_sel), diff_mode ? (m_sel & 7) : m_sel);
        chk("R9 gain", int'(gain_code), m_gain);
        @(posedge clk);
        model_edge(a, w, d, p, cv);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(4 + (i % 2));
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_wdata = 0;
        pacer_tick = 0; cvt_result = 0; diff_mode = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10 reset state
        bus_addr = 4'h5; #1;
        chk("R10 busy/result hi after reset", int'(bus_rdata), 0);
        chk("R10 irq after reset", int'(irq_req), 0);
        chk("R10 selector after reset", int'(mux_sel), 0);
        @(negedge clk);

        // R4: mode 000 ignores both sources
        cyc(12, 1, 8'h55); cyc(5, 0, 0, 1); idle(3);

        // R3: software trigger, polled
        cyc(11, 1, 8'h01);
        cyc(12, 1, 8'hA7);
        idle(CONV + 3);
        // R5: retrigger while busy, and pacer ignored in mode 001
        cyc(12, 1, 8'h00); cyc(5); cyc(12, 1, 8'hFF); cyc(5, 0, 0, 1);
        idle(CONV + 2);

        // R4: pacer polled; software ignored
        cyc(11, 1, 8'h02);
        cyc(12, 1, 8'h01); idle(2);
        cyc(5, 0, 0, 1); cyc(5, 0, 0, 1); idle(CONV + 2);

        // R6/R7: interrupt mode over every line code
        for (int c = 0; c < 8; c++) begin
            cyc(11, 1, 8'h06 | (c << 4));
            cyc(5, 0, 0, 1); idle(CONV + 2);
            cyc(5, 0, 0, 1); idle(CONV + 2);   // second completion while set
            cyc(8, 1, 8'h3C); idle(2);          // clear
        end
        // R6: clear coinciding with completion wins
        cyc(11, 1, 8'h46);
        cyc(5, 0, 0, 1); idle(CONV - 1);
        cyc(8, 1, 8'h00); idle(3);
        // R6: completions in polled pacer mode do not set the status
        cyc(11, 1, 8'h42); cyc(5, 0, 0, 1); idle(CONV + 2);

        // R8/R9: selector and gain
        cyc(10, 1, 8'hFF); cyc(9, 1, 8'hFE); idle(1);
        diff_mode = 1; idle(2);
        cyc(10, 1, 8'h0B); idle(1);
        diff_mode = 0; idle(2);
        cyc(9, 1, 8'h01); cyc(10, 1, 8'hF3); idle(2);

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int a, d, r;
            r = $urandom % 16;
            a = $urandom % 16;
            d = $urandom % 256;
            if (a == 11 && (d % 8) > 2 && (d % 8) != 6) d = d & 8'hF6;
            if (i % 500 == 250) diff_mode = ~diff_mode;
            if (r < 3) cyc(a, 1, d, ($urandom % 8) == 0);
            else cyc(a, 0, 0, ($urandom % 10) == 0);
        end
        idle(CONV + 2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule